// File: doc/BRIEF.md
# Tamper-Protected Backup Register File

This block keeps a small bank of 16-bit backup data registers and wipes them when a tamper input shows its active edge. Software picks the active edge (rising or falling), turns detection on, and may let a detected tamper raise an interrupt. A tamper sets a sticky event flag and, when interrupts are on, a sticky interrupt flag. Software clears both flags by writing ones to clear bits.

The pin is first resynchronised. The chosen polarity is then applied, and the result is gated by the detection enable before the edge detector sees it. As a result, turning detection on while the pin already sits at its active level counts as an event straight away. After any tamper, the data registers ignore writes until software turns detection off and back on. This stops software from refilling the bank while the pin may still be showing a tamper. If a data write and a tamper land in the same cycle, the wipe wins.

Access is through a plain register bus with an address, write data, a write strobe and combinational read data.

Top module: `tamper_backup_regs`

## Requirements
- R1: After reset, every address reads 0 and `tamperIrq` is low.
- R2: Register map. Address 0 is the control register: bit 0 is the enable and bit 1 is the polarity. Address 1 is the control/status register: bit 0 is the interrupt enable (read/write), writing 1 to bit 1 clears the event flag, writing 1 to bit 2 clears the interrupt flag, bit 8 reads the event flag and bit 9 reads the interrupt flag. Bits 1 and 2 read 0. With polarity 0 and detection enabled, a 0-to-1 pin transition sets the event flag within 4 clocks. A 1-to-0 transition does not.
- R3: With polarity 1 and detection enabled, a 1-to-0 pin transition sets the event flag within 4 clocks. A 0-to-1 transition does not.
- R4: A tamper event sets every data register to 0.
- R5: Enabling detection while the pin is already at its active level raises exactly one event. The flag is visible one clock after the enabling write. The steady active level raises no further event.
- R6: When the interrupt enable is 1, a tamper event sets the interrupt flag, and `tamperIrq` follows that flag. When the interrupt enable is 0, an event leaves the interrupt flag and `tamperIrq` at 0.
- R7: Writing 1 to a clear bit clears the matching flag on the next clock, and `tamperIrq` drops with the interrupt flag.
- R8: After a tamper event, writes to data registers are ignored, even after the flags are cleared. They are accepted again once the enable has been written 0 and then written 1.
- R9: If a data register write and a tamper event fall in the same clock, that register ends at 0.
- R10: Data registers sit at addresses 2 to 2+N-1 (N=10 by default) and read back the last accepted write. Writes to any other address above 1 are dropped, and such addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 5 | Register address |
| busWdata | input | 16 | Write data |
| busWrite | input | 1 | Write strobe, one write per clock it is high |
| busRdata | output | 16 | Combinational read data for `busAddr` |
| tamperPin | input | 1 | Tamper input, asynchronous |
| tamperIrq | output | 1 | Interrupt output, equal to the interrupt flag |

## Verification
A wrong edge detector or gate shows up as an event flag that is set or missing at address 1 within four clocks of a pin change. For the enable-time event, the error is visible on the very next clock. A broken wipe leaves a nonzero value readable from a data address right away. A broken write lock shows up as a write that either sticks or is lost on the following read. Comparing these reads and `tamperIrq` at fixed cycle offsets from each pin change or bus write locates the faulty stage to within one clock.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
  localparam int DATA_BASE = 2;

  typedef struct packed {
    logic clearAll;
    logic writeOk;
  } dpStrobe_t;
endpackage

// File: rtl/tamper_ctrl.sv
module tamper_ctrl
  import tamper_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWrite,
  input  logic              tamperPin,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] ctrlRdata,
  output logic              tamperIrq
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

  logic [SYNC_STAGES-1:0] syncChain;
  logic pinSync, activeLvl, gatedLvl, prevGated, tamperEvent;
  logic tamperEn, polarity, irqEn;
  logic eventFlag, irqFlag, writeLock, sawOff;
  logic ctrlSel, statSel, clrEvt, clrIrq;

  // resynchronise the asynchronous pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], tamperPin};
  end
  assign pinSync = syncChain[SYNC_STAGES-1];

  // polarity first, then gate with enable, then edge detect
  assign activeLvl   = polarity ? ~pinSync : pinSync;
  assign gatedLvl    = activeLvl & tamperEn;
  assign tamperEvent = gatedLvl & ~prevGated;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevGated <= 1'b0;
    else       prevGated <= gatedLvl;
  end

  assign ctrlSel = busWrite && (busAddr == CTRL_A);
  assign statSel = busWrite && (busAddr == STAT_A);
  assign clrEvt  = statSel && busWdata[1];
  assign clrIrq  = statSel && busWdata[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tamperEn <= 1'b0;
      polarity <= 1'b0;
      irqEn    <= 1'b0;
    end else begin
      if (ctrlSel) begin
        tamperEn <= busWdata[0];
        polarity <= busWdata[1];
      end
      if (statSel) irqEn <= busWdata[0];
    end
  end

  // sticky flags: a new event beats a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventFlag <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      if (tamperEvent)  eventFlag <= 1'b1;
      else if (clrEvt)  eventFlag <= 1'b0;
      if (tamperEvent && irqEn) irqFlag <= 1'b1;
      else if (clrIrq)          irqFlag <= 1'b0;
    end
  end

  // write lock: set by an event, released only by enable off then on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeLock <= 1'b0;
      sawOff    <= 1'b0;
    end else if (tamperEvent) begin
      writeLock <= 1'b1;
      sawOff    <= 1'b0;
    end else if (writeLock) begin
      if (!tamperEn) sawOff <= 1'b1;
      else if (sawOff) begin
        writeLock <= 1'b0;
        sawOff    <= 1'b0;
      end
    end
  end

  assign strobe.clearAll = tamperEvent;
  assign strobe.writeOk  = ~writeLock;
  assign tamperIrq       = irqFlag;

  always_comb begin
    ctrlRdata = '0;
    if (busAddr == CTRL_A) begin
      ctrlRdata[0] = tamperEn;
      ctrlRdata[1] = polarity;
    end else if (busAddr == STAT_A) begin
      ctrlRdata[0] = irqEn;
      ctrlRdata[8] = eventFlag;
      ctrlRdata[9] = irqFlag;
    end
  end

  p_flag_sets_r2: assert property (@(posedge clk) disable iff (!rstN)
    tamperEvent |=> (eventFlag && writeLock));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    tamperEvent |=> !tamperEvent);

  p_irq_needs_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tamperIrq) |-> $past(irqEn));

  p_clear_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clrEvt && !tamperEvent) |=> !eventFlag);

  p_unlock_enabled_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(writeLock) |-> tamperEn);
endmodule

// File: rtl/tamper_regfile.sv
module tamper_regfile
  import tamper_pkg::*;
#(
  parameter int NUM_DATA = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWrite,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] dataRdata
);
  logic [NUM_DATA-1:0][DATA_W-1:0] dataMem;
  logic [NUM_DATA-1:0] hit;

  for (genvar i = 0; i < NUM_DATA; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(DATA_BASE + i);
    assign hit[i] = (busAddr == MY_ADDR);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataMem <= '0;
    else begin
      for (int i = 0; i < NUM_DATA; i++) begin
        if (strobe.clearAll)                         dataMem[i] <= '0;
        else if (strobe.writeOk && busWrite && hit[i]) dataMem[i] <= busWdata;
      end
    end
  end

  always_comb begin
    dataRdata = '0;
    for (int i = 0; i < NUM_DATA; i++)
      if (hit[i]) dataRdata = dataMem[i];
  end

  p_clear_on_event_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (dataMem == '0));

  p_locked_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.writeOk && !strobe.clearAll) |=> $stable(dataMem));
endmodule

// File: rtl/tamper_backup_regs.sv
module tamper_backup_regs
  import tamper_pkg::*;
#(
  parameter int NUM_DATA = 10,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWrite,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tamperPin,
  output logic              tamperIrq
);
  dpStrobe_t strobe;
  logic [DATA_W-1:0] ctrlRdata, dataRdata;

  tamper_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWrite(busWrite), .tamperPin(tamperPin), .strobe(strobe),
    .ctrlRdata(ctrlRdata), .tamperIrq(tamperIrq)
  );

  tamper_regfile #(.NUM_DATA(NUM_DATA), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWrite(busWrite), .strobe(strobe), .dataRdata(dataRdata)
  );

  assign busRdata = ctrlRdata | dataRdata;
endmodule

// File: tb/tb_tamper_backup_regs.sv
`timescale 1ns/100ps
module tb_tamper_backup_regs;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic [15:0] busWdata = '0;
  logic busWrite = 1'b0;
  logic [15:0] busRdata;
  logic tamperPin = 1'b0;
  logic tamperIrq;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  tamper_backup_regs dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWrite(busWrite), .busRdata(busRdata), .tamperPin(tamperPin),
    .tamperIrq(tamperIrq)
  );

  // {address, write data, expected read back}
  localparam logic [36:0] VEC [8] = '{
    {5'd2,  16'h1234, 16'h1234},
    {5'd3,  16'hBEEF, 16'hBEEF},
    {5'd11, 16'hA5A5, 16'hA5A5},
    {5'd7,  16'h0F0F, 16'h0F0F},
    {5'd12, 16'hFFFF, 16'h0000},
    {5'd31, 16'h1111, 16'h0000},
    {5'd2,  16'h0000, 16'h0000},
    {5'd2,  16'hC3C3, 16'hC3C3}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [4:0] a, input logic [15:0] exp);
    @(negedge clk);
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    // R1 reset state
    rdCheck("R1 ctrl", 5'd0, 16'h0);
    rdCheck("R1 stat", 5'd1, 16'h0);
    rdCheck("R1 data2", 5'd2, 16'h0);
    rdCheck("R1 data11", 5'd11, 16'h0);
    check("R1 irq", {15'b0, tamperIrq}, 16'h0);

    // R10 vector table
    for (int i = 0; i < 8; i++) begin
      busWr(VEC[i][36:32], VEC[i][31:16]);
      rdCheck("R10 readback", VEC[i][36:32], VEC[i][15:0]);
    end

    // R2 polarity 0: enable with pin low gives no event
    busWr(5'd0, 16'h0001);
    waitCyc(4);
    rdCheck("R2 no spurious", 5'd1, 16'h0000);
    rdCheck("R2 data kept", 5'd11, 16'hA5A5);
    tamperPin = 1'b1;
    waitCyc(4);
    rdCheck("R2 rising sets flag", 5'd1, 16'h0100);
    check("R6 irq off when disabled", {15'b0, tamperIrq}, 16'h0);
    rdCheck("R4 data2 wiped", 5'd2, 16'h0);
    rdCheck("R4 data11 wiped", 5'd11, 16'h0);
    rdCheck("R4 data7 wiped", 5'd7, 16'h0);

    // R7 clear, R8 locked until toggle
    busWr(5'd1, 16'h0002);
    rdCheck("R7 event cleared", 5'd1, 16'h0);
    busWr(5'd2, 16'hABCD);
    rdCheck("R8 write ignored", 5'd2, 16'h0);
    tamperPin = 1'b0;
    waitCyc(4);
    rdCheck("R2 falling ignored", 5'd1, 16'h0);
    busWr(5'd0, 16'h0000);
    busWr(5'd2, 16'h4321);
    rdCheck("R8 still locked when off", 5'd2, 16'h0);
    busWr(5'd0, 16'h0001);
    busWr(5'd2, 16'h1234);
    rdCheck("R8 unlocked", 5'd2, 16'h1234);

    // R5 enable while at active level (polarity 1, pin low), R6 irq
    busWr(5'd1, 16'h0001);
    busWr(5'd0, 16'h0000);
    busWr(5'd0, 16'h0003);
    rdCheck("R5 immediate event", 5'd1, 16'h0301);
    check("R6 irq asserted", {15'b0, tamperIrq}, 16'h1);
    rdCheck("R5 data wiped", 5'd2, 16'h0);
    busWr(5'd1, 16'h0007);
    rdCheck("R7 both cleared", 5'd1, 16'h0001);
    check("R7 irq dropped", {15'b0, tamperIrq}, 16'h0);
    waitCyc(4);
    rdCheck("R5 only one event", 5'd1, 16'h0001);

    // R3 polarity 1
    tamperPin = 1'b1;
    waitCyc(4);
    rdCheck("R3 rising ignored", 5'd1, 16'h0001);
    busWr(5'd0, 16'h0002);
    busWr(5'd0, 16'h0003);
    busWr(5'd3, 16'h5555);
    rdCheck("R8 unlocked again", 5'd3, 16'h5555);
    tamperPin = 1'b0;
    waitCyc(4);
    rdCheck("R3 falling sets flags", 5'd1, 16'h0301);
    check("R6 irq on falling", {15'b0, tamperIrq}, 16'h1);
    rdCheck("R4 data3 wiped", 5'd3, 16'h0);

    // R9 write and event in the same clock
    busWr(5'd1, 16'h0007);
    tamperPin = 1'b1;
    waitCyc(4);
    busWr(5'd0, 16'h0002);
    busWr(5'd0, 16'h0003);
    busWr(5'd4, 16'h7777);
    rdCheck("R9 setup", 5'd4, 16'h7777);
    @(negedge clk);
    tamperPin = 1'b0;
    @(negedge clk);
    busWr(5'd4, 16'h9999);
    rdCheck("R9 clear wins", 5'd4, 16'h0);
    rdCheck("R9 flag set", 5'd1, 16'h0301);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule